// File: doc/BRIEF.md
# Dual-Sensor Serial Interface Controller

This block sits between a simple request interface and two sensors that share one serial bus: an eight-input 12-bit ADC and a 10-bit temperature sensor. A one-cycle `go` pulse starts a request. `pick_temp` chooses the device, and `req_chan` chooses the ADC input. The block generates the serial clock and the outgoing control bits. It drives a separate select line for each device, shifts in the reply, and places the result on a parallel bus for that device together with a one-cycle `done` pulse.

The ADC needs some housekeeping, and the block runs it without being asked. After reset it issues two dummy frames. It writes the ADC control word only when the requested channel is different from the last one programmed. It raises `done` only for the frame that carries the requested result. Every frame is 16 serial clocks long. The serial clock runs at the system clock divided by `CLK_DIV`, idles high, changes data on its falling edge and samples on its rising edge.

The sequencer has these states: `ST_GAP` (the reset state, a `CLK_DIV`-cycle pause between frames), `ST_DUMMY`, `ST_IDLE`, `ST_CTRL_WR`, `ST_ADC_RD` and `ST_TEMP_RD`. Its transitions are:
- `ST_GAP` to `ST_DUMMY` while fewer than two dummy frames are done.
- `ST_GAP` to `ST_ADC_RD` when a control write is waiting for its read.
- `ST_GAP` to `ST_IDLE` otherwise.
- `ST_IDLE` to `ST_TEMP_RD`, `ST_CTRL_WR` or `ST_ADC_RD` on `go`.
- Every frame state returns to `ST_GAP` when its frame ends.

Top module: `dual_sensor_ctrl`

## Requirements
- R1: During reset `sensor_rst_n` is low. After reset the block runs exactly two ADC dummy frames, in which all 16 bits sent on `sdi` are 1. No `done` follows these frames.
- R2: With `pick_temp`=1 only `temp_ce` is asserted (high) during the frame. With `pick_temp`=0 only `adc_cs_n` is asserted (low). The two selects are never active together.
- R3: `sclk` is high whenever no device is selected. Each frame has exactly 16 rising edges of `sclk`, spaced `CLK_DIV` system clocks apart. `sdi` changes only while `sclk` is low or no device is selected.
- R4: An ADC request with no channel programmed since reset, or with a channel different from the last one programmed, is served by a control-write frame and then a read frame. The control word has bit 15 = 1, the channel in bits 12:10 and all other bits 0. The read frame sends 16 zeros.
- R5: An ADC request for the channel already programmed is served by a single read frame with no control write.
- R6: After an ADC read, `adc_data` holds the last 12 bits received (bits 11:0 of the 16-bit frame, sent MSB first) and `adc_tag` holds the 3 bits just before them (bits 14:12).
- R7: After a temperature read, `temp_data` holds the first 10 bits received (bits 15:6). `req_chan` is ignored and the programmed ADC channel is left unchanged.
- R8: `done` lasts exactly one system clock and follows only a final read frame. `adc_data`, `adc_tag` and `temp_data` change only in the cycle where `done` is high.
- R9: A `go` that arrives while the startup sequence or a request is in progress is ignored. A new request is accepted from `CLK_DIV`+1 clocks after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle request pulse |
| pick_temp | input | 1 | 1 targets the temperature sensor, 0 targets the ADC |
| req_chan | input | 3 | ADC input channel for the request |
| sdo | input | 1 | Serial data returned by the sensors |
| sclk | output | 1 | Serial clock, idles high |
| sensor_rst_n | output | 1 | Active-low reset toward the sensors |
| sdi | output | 1 | Serial control bits toward the sensors |
| adc_cs_n | output | 1 | ADC select, active low |
| temp_ce | output | 1 | Temperature sensor select, active high |
| done | output | 1 | One-cycle pulse when a result is ready |
| adc_data | output | 12 | ADC conversion result |
| adc_tag | output | 3 | Channel the ADC result belongs to |
| temp_data | output | 10 | Temperature result |

## Verification
The hardest cases to reach from the ports are a `go` that lands during the startup dummy frames, and the decision to write or skip the control word, which depends on hidden history. The bench pulses `go` a few cycles after reset and checks that nothing follows. It then sweeps every ordered pair of channels, with temperature reads mixed in, so that each write-or-skip decision and each preserved channel is observed. A behavioural ADC model answers with data from the channel its own control register holds. Because of that, a missing or wrong control write shows up as a wrong `adc_tag` and a wrong `adc_data`.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_CTRL_WR,
        ST_ADC_RD,
        ST_TEMP_RD,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        FK_DUMMY,
        FK_CTRL,
        FK_READ,
        FK_TEMP
    } frame_kind_t;

endpackage

// File: rtl/dsc_reset_release.sv
module dsc_reset_release (
    input  logic clk,
    input  logic rst_n,
    output logic rst_out_n
);

    logic stage_q;
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            stage_q <= 1'b1;
            out_q   <= stage_q;
        end
    end

    assign rst_out_n = out_q;

endmodule

// File: rtl/dsc_serial_engine.sv
// Runs one frame: clock division, bit launch on the falling edge and
// capture on the rising edge. CLK_DIV must be even and at least 4.
module dsc_serial_engine #(
    parameter int FRAME_BITS = 16,
    parameter int CLK_DIV    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FRAME_BITS-1:0] tx_i,
    input  logic                  sdo_i,
    output logic                  active_o,
    output logic                  sclk_o,
    output logic                  sdi_o,
    output logic [FRAME_BITS-1:0] rx_o,
    output logic                  frame_done_o
);

    localparam int PW   = $clog2(CLK_DIV);
    localparam int BW   = $clog2(FRAME_BITS + 1);
    localparam int HALF = CLK_DIV / 2;

    logic                  active_q;
    logic                  sclk_q;
    logic                  sdi_q;
    logic                  done_q;
    logic [PW-1:0]         ph_q;
    logic [BW-1:0]         bit_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            sdi_q    <= 1'b0;
            done_q   <= 1'b0;
            ph_q     <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start_i) begin
                    active_q <= 1'b1;
                    tx_q     <= tx_i;
                    ph_q     <= '0;
                    bit_q    <= '0;
                end
            end else begin
                ph_q <= (ph_q == PW'(CLK_DIV - 1)) ? '0 : ph_q + 1'b1;
                // falling edge: launch next control bit
                if (ph_q == PW'(0) && bit_q != BW'(FRAME_BITS)) begin
                    sclk_q <= 1'b0;
                    sdi_q  <= tx_q[FRAME_BITS-1];
                    tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
                end
                // rising edge: capture reply bit
                if (ph_q == PW'(HALF) && bit_q != BW'(FRAME_BITS)) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[FRAME_BITS-2:0], sdo_i};
                    bit_q  <= bit_q + 1'b1;
                end
                // tail of the last period: release the select
                if (ph_q == PW'(CLK_DIV - 1) && bit_q == BW'(FRAME_BITS)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    sdi_q    <= 1'b0;
                end
            end
        end
    end

    assign active_o     = active_q;
    assign sclk_o       = sclk_q;
    assign sdi_o        = sdi_q;
    assign rx_o         = rx_q;
    assign frame_done_o = done_q;

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int CH_BITS      = 3,
    parameter int GAP_CYCLES   = 4,
    parameter int DUMMY_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic               sel_temp_i,
    input  logic [CH_BITS-1:0] chan_i,
    input  logic               frame_done_i,
    output logic               start_o,
    output frame_kind_t        kind_o,
    output logic [CH_BITS-1:0] chan_o,
    output logic               final_done_o,
    output logic               final_temp_o
);

    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int DW = $clog2(DUMMY_FRAMES + 1);

    seq_state_t         state_q, state_d;
    logic [GW-1:0]      gap_q;
    logic [DW-1:0]      dummy_q;
    logic [CH_BITS-1:0] req_chan_q;
    logic [CH_BITS-1:0] last_chan_q;
    logic               last_valid_q;
    logic               then_read_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) begin
                    if (sel_temp_i)
                        state_d = ST_TEMP_RD;
                    else if (!last_valid_q || chan_i != last_chan_q)
                        state_d = ST_CTRL_WR;
                    else
                        state_d = ST_ADC_RD;
                end
            end
            ST_DUMMY, ST_CTRL_WR, ST_ADC_RD, ST_TEMP_RD: begin
                if (frame_done_i)
                    state_d = ST_GAP;
            end
            ST_GAP: begin
                if (gap_q == GW'(GAP_CYCLES - 1)) begin
                    if (dummy_q < DW'(DUMMY_FRAMES))
                        state_d = ST_DUMMY;
                    else if (then_read_q)
                        state_d = ST_ADC_RD;
                    else
                        state_d = ST_IDLE;
                end
            end
            default: state_d = ST_GAP;
        endcase
    end

    // state register and sequencing memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_GAP;
            gap_q        <= '0;
            dummy_q      <= '0;
            req_chan_q   <= '0;
            last_chan_q  <= '0;
            last_valid_q <= 1'b0;
            then_read_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gap_q   <= (state_q == ST_GAP && state_d == ST_GAP) ? gap_q + 1'b1 : '0;
            if (state_q == ST_DUMMY && frame_done_i)
                dummy_q <= dummy_q + 1'b1;
            if (state_q == ST_IDLE && go_i && !sel_temp_i)
                req_chan_q <= chan_i;
            if (state_q == ST_CTRL_WR && frame_done_i) begin
                last_chan_q  <= req_chan_q;
                last_valid_q <= 1'b1;
                then_read_q  <= 1'b1;
            end else if (state_q == ST_ADC_RD) begin
                then_read_q  <= 1'b0;
            end
        end
    end

    // outputs toward the serial engine and result registers
    always_comb begin
        start_o = (state_d != state_q) &&
                  (state_d == ST_DUMMY || state_d == ST_CTRL_WR ||
                   state_d == ST_ADC_RD || state_d == ST_TEMP_RD);
        unique case (state_d)
            ST_DUMMY:   kind_o = FK_DUMMY;
            ST_CTRL_WR: kind_o = FK_CTRL;
            ST_TEMP_RD: kind_o = FK_TEMP;
            default:    kind_o = FK_READ;
        endcase
        chan_o       = (state_q == ST_IDLE) ? chan_i : req_chan_q;
        final_done_o = frame_done_i && (state_q == ST_ADC_RD || state_q == ST_TEMP_RD);
        final_temp_o = (state_q == ST_TEMP_RD);
    end

endmodule

// File: rtl/dual_sensor_ctrl.sv
module dual_sensor_ctrl
    import dsc_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int CH_BITS      = 3,
    parameter int ADC_BITS     = 12,
    parameter int TEMP_BITS    = 10,
    parameter int FRAME_BITS   = 16,
    parameter int DUMMY_FRAMES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 pick_temp,
    input  logic [CH_BITS-1:0]   req_chan,
    input  logic                 sdo,
    output logic                 sclk,
    output logic                 sensor_rst_n,
    output logic                 sdi,
    output logic                 adc_cs_n,
    output logic                 temp_ce,
    output logic                 done,
    output logic [ADC_BITS-1:0]  adc_data,
    output logic [CH_BITS-1:0]   adc_tag,
    output logic [TEMP_BITS-1:0] temp_data
);

    localparam int WR_BIT = FRAME_BITS - 1;
    localparam int CH_LSB = FRAME_BITS - 3 - CH_BITS;

    logic                  start;
    frame_kind_t           kind;
    logic [CH_BITS-1:0]    frame_chan;
    logic                  final_done;
    logic                  final_temp;
    logic                  frame_done;
    logic                  active;
    logic [FRAME_BITS-1:0] tx_word;
    logic [FRAME_BITS-1:0] rx_word;
    logic                  is_temp_q;
    logic                  done_q;
    logic [ADC_BITS-1:0]   adc_q;
    logic [CH_BITS-1:0]    tag_q;
    logic [TEMP_BITS-1:0]  temp_q;

    dsc_reset_release u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_out_n (sensor_rst_n)
    );

    dsc_sequencer #(
        .CH_BITS      (CH_BITS),
        .GAP_CYCLES   (CLK_DIV),
        .DUMMY_FRAMES (DUMMY_FRAMES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .sel_temp_i   (pick_temp),
        .chan_i       (req_chan),
        .frame_done_i (frame_done),
        .start_o      (start),
        .kind_o       (kind),
        .chan_o       (frame_chan),
        .final_done_o (final_done),
        .final_temp_o (final_temp)
    );

    // control word for the frame about to start
    always_comb begin
        tx_word = '0;
        unique case (kind)
            FK_DUMMY: tx_word = '1;
            FK_CTRL: begin
                tx_word[WR_BIT]                 = 1'b1;
                tx_word[CH_LSB +: CH_BITS]      = frame_chan;
            end
            FK_READ, FK_TEMP: tx_word = '0;
            default: tx_word = '0;
        endcase
    end

    dsc_serial_engine #(
        .FRAME_BITS (FRAME_BITS),
        .CLK_DIV    (CLK_DIV)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .tx_i         (tx_word),
        .sdo_i        (sdo),
        .active_o     (active),
        .sclk_o       (sclk),
        .sdi_o        (sdi),
        .rx_o         (rx_word),
        .frame_done_o (frame_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_temp_q <= 1'b0;
            done_q    <= 1'b0;
            adc_q     <= '0;
            tag_q     <= '0;
            temp_q    <= '0;
        end else begin
            if (start)
                is_temp_q <= (kind == FK_TEMP);
            done_q <= final_done;
            if (final_done) begin
                if (final_temp) begin
                    temp_q <= rx_word[FRAME_BITS-1 -: TEMP_BITS];
                end else begin
                    adc_q <= rx_word[ADC_BITS-1:0];
                    tag_q <= rx_word[ADC_BITS +: CH_BITS];
                end
            end
        end
    end

    assign adc_cs_n  = !(active && !is_temp_q);
    assign temp_ce   = active && is_temp_q;
    assign done      = done_q;
    assign adc_data  = adc_q;
    assign adc_tag   = tag_q;
    assign temp_data = temp_q;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int CH_BITS   = 3,
    parameter int ADC_BITS  = 12,
    parameter int TEMP_BITS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 sdi,
    input logic                 adc_cs_n,
    input logic                 temp_ce,
    input logic                 done,
    input logic [ADC_BITS-1:0]  adc_data,
    input logic [CH_BITS-1:0]   adc_tag,
    input logic [TEMP_BITS-1:0] temp_data
);

    logic bus_idle;
    assign bus_idle = adc_cs_n && !temp_ce;

    p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_cs_n && temp_ce));

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> sclk);

    p_sdi_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdi) |-> (!sclk || bus_idle));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_idle);

    p_adc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({adc_data, adc_tag}) |-> done);

    p_temp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(temp_data) |-> done);

endmodule

bind dual_sensor_ctrl dsc_checker #(
    .CH_BITS   (CH_BITS),
    .ADC_BITS  (ADC_BITS),
    .TEMP_BITS (TEMP_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .adc_cs_n  (adc_cs_n),
    .temp_ce   (temp_ce),
    .done      (done),
    .adc_data  (adc_data),
    .adc_tag   (adc_tag),
    .temp_data (temp_data)
);

// File: tb/test_dual_sensor_ctrl.sv
module test_dual_sensor_ctrl;

    localparam int CLK_DIV = 4;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        pick_temp = 1'b0;
    logic [2:0]  req_chan = 3'd0;
    logic        sdo = 1'b0;
    logic        sclk, sensor_rst_n, sdi, adc_cs_n, temp_ce, done;
    logic [11:0] adc_data;
    logic [2:0]  adc_tag;
    logic [9:0]  temp_data;

    always #2ns clk = ~clk;

    dual_sensor_ctrl i_dual_sensor_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .pick_temp(pick_temp),
        .req_chan(req_chan), .sdo(sdo), .sclk(sclk), .sensor_rst_n(sensor_rst_n),
        .sdi(sdi), .adc_cs_n(adc_cs_n), .temp_ce(temp_ce), .done(done),
        .adc_data(adc_data), .adc_tag(adc_tag), .temp_data(temp_data)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int n_done = 0;

    // ---------------- behavioural sensors ----------------
    int          adc_idx = 0, temp_idx = 0, rises = 0, last_rise = 0;
    int          n_dummy = 0, n_write = 0, n_read = 0, n_temp = 0;
    int          n_adc_fr = 0, bad_frames = 0, bad_period = 0;
    bit          adc_open = 0, temp_open = 0;
    logic [15:0] adc_rx = '0, adc_resp = '0, temp_rx = '0, temp_resp = '0;
    logic [15:0] last_write = '0, last_read_resp = '0, last_temp_resp = '0;
    logic [2:0]  dev_ch = 3'd0;

    function automatic logic [11:0] adc_val(input int ch, input int k);
        return 12'((ch * 293 + k * 71 + 9) % 4096);
    endfunction

    function automatic logic [9:0] temp_val(input int k);
        return 10'((k * 53 + 17) % 1024);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (done) n_done++;
    end

    always @(negedge adc_cs_n) begin
        adc_open = 1; adc_idx = 0; adc_rx = '0; rises = 0;
        adc_resp = {1'b0, dev_ch, adc_val(int'(dev_ch), n_adc_fr)};
        n_adc_fr++;
    end

    always @(posedge temp_ce) begin
        temp_open = 1; temp_idx = 0; temp_rx = '0; rises = 0;
        temp_resp = {temp_val(n_temp), 6'b0};
    end

    always @(negedge sclk) begin
        if (!adc_cs_n && adc_idx < 16) sdo = adc_resp[15 - adc_idx];
        else if (temp_ce && temp_idx < 16) sdo = temp_resp[15 - temp_idx];
    end

    always @(posedge sclk) begin
        if (!adc_cs_n || temp_ce) begin
            if (rises > 0 && cyc - last_rise != CLK_DIV) bad_period++;
            last_rise = cyc;
            rises++;
        end
        if (!adc_cs_n) begin adc_rx = {adc_rx[14:0], sdi}; adc_idx++; end
        else if (temp_ce) begin temp_rx = {temp_rx[14:0], sdi}; temp_idx++; end
    end

    always @(posedge adc_cs_n) begin
        if (adc_open) begin
            adc_open = 0;
            if (adc_idx != 16) bad_frames++;
            if (adc_rx == 16'hFFFF) n_dummy++;
            else if (adc_rx[15]) begin n_write++; last_write = adc_rx; dev_ch = adc_rx[12:10]; end
            else if (adc_rx == 16'h0000) begin n_read++; last_read_resp = adc_resp; end
            else bad_frames++;
        end
    end

    always @(negedge temp_ce) begin
        if (temp_open) begin
            temp_open = 0;
            if (temp_idx != 16 || temp_rx != 16'h0000) bad_frames++;
            last_temp_resp = temp_resp;
            n_temp++;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_go(input bit t, input logic [2:0] ch);
        @(negedge clk);
        go = 1'b1; pick_temp = t; req_chan = ch;
        @(negedge clk);
        go = 1'b0;
    endtask

    // waits for done; returns 1 if seen; also notes which selects were seen
    task automatic wait_done(output bit seen, output bit saw_adc, output bit saw_temp);
        seen = 0; saw_adc = 0; saw_temp = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (!adc_cs_n) saw_adc = 1;
            if (temp_ce) saw_temp = 1;
            if (done) seen = 1;
        end
    endtask

    bit         prog_valid = 0;
    logic [2:0] prog_ch = 3'd0;

    task automatic do_adc(input logic [2:0] ch, input bit poke_busy);
        int w0, r0, t0, d0;
        bit seen, sa, st, exp_wr;
        exp_wr = !prog_valid || ch != prog_ch;
        w0 = n_write; r0 = n_read; t0 = n_temp; d0 = n_done;
        pulse_go(1'b0, ch);
        if (poke_busy) begin
            idle_cycles(20);
            pulse_go(1'b1, ~ch);   // R9: must be ignored
        end
        wait_done(seen, sa, st);
        chk(seen, "R8", "done after adc request", int'(seen), 1);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", int'(done), 0);
        chk(sa && !st, "R2", "adc select only", int'(st), 0);
        if (exp_wr) begin
            chk(n_write - w0 == 1, "R4", "control writes", n_write - w0, 1);
            chk(last_write == {1'b1, 2'b00, ch, 10'b0}, "R4", "control word",
                int'(last_write), int'({1'b1, 2'b00, ch, 10'b0}));
        end else begin
            chk(n_write == w0, "R5", "no control write", n_write - w0, 0);
        end
        chk(n_read - r0 == 1, "R4", "read frames", n_read - r0, 1);
        chk(adc_data == last_read_resp[11:0], "R6", "adc_data",
            int'(adc_data), int'(last_read_resp[11:0]));
        chk(adc_tag == ch, "R6", "adc_tag", int'(adc_tag), int'(ch));
        chk(adc_data == adc_val(int'(ch), n_adc_fr - 1), "R6", "adc value of channel",
            int'(adc_data), int'(adc_val(int'(ch), n_adc_fr - 1)));
        prog_valid = 1; prog_ch = ch;
        if (poke_busy) begin
            idle_cycles(200);
            chk(n_temp == t0, "R9", "busy go started frame", n_temp - t0, 0);
            chk(n_done - d0 == 1, "R9", "done count", n_done - d0, 1);
        end
        idle_cycles(CLK_DIV + 2);
    endtask

    task automatic do_temp(input logic [2:0] junk_ch);
        int w0, r0;
        bit seen, sa, st;
        logic [11:0] a0;
        w0 = n_write; r0 = n_read; a0 = adc_data;
        pulse_go(1'b1, junk_ch);
        wait_done(seen, sa, st);
        chk(seen, "R8", "done after temp request", int'(seen), 1);
        chk(st && !sa, "R2", "temp select only", int'(sa), 0);
        chk(temp_data == last_temp_resp[15:6], "R7", "temp_data",
            int'(temp_data), int'(last_temp_resp[15:6]));
        chk(n_write == w0 && n_read == r0, "R7", "adc frames during temp",
            n_write - w0 + n_read - r0, 0);
        chk(adc_data == a0, "R8", "adc_data held", int'(adc_data), int'(a0));
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", int'(done), 0);
        idle_cycles(CLK_DIV + 2);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        idle_cycles(5);
        chk(sensor_rst_n == 1'b0, "R1", "sensor reset during reset", int'(sensor_rst_n), 0);
        chk(adc_cs_n && !temp_ce, "R2", "selects idle in reset", int'(temp_ce), 0);
        chk(sclk == 1'b1, "R3", "sclk idle in reset", int'(sclk), 1);
        chk(done == 1'b0 && adc_data == 0 && temp_data == 0, "R8", "outputs in reset",
            int'(done), 0);
        rst_n = 1'b1;
        idle_cycles(3);
        pulse_go(1'b0, 3'd5);      // lands during startup frames: ignored
        idle_cycles(400);
        chk(sensor_rst_n == 1'b1, "R1", "sensor reset released", int'(sensor_rst_n), 1);
        chk(n_dummy == 2, "R1", "dummy frames", n_dummy, 2);
        chk(n_write == 0 && n_read == 0, "R9", "go during startup", n_write + n_read, 0);
        chk(n_done == 0, "R1", "no done after dummies", n_done, 0);

        do_adc(3'd4, 1'b0);        // first request always writes (R4)
        do_adc(3'd4, 1'b0);        // same channel: read only (R5)
        do_adc(3'd6, 1'b1);        // busy go ignored (R9)
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                do_adc(3'(a), 1'b0);
                do_adc(3'(b), 1'b0);
            end
            do_temp(3'(a ^ 3));
            do_adc(3'(7), 1'b0);   // R7: channel state kept across temp reads
        end
        do_temp(3'd0);
        do_temp(3'd7);
        chk(n_dummy == 2, "R1", "no further dummies", n_dummy, 2);
        chk(bad_frames == 0, "R3", "frames without 16 edges or bad word", bad_frames, 0);
        chk(bad_period == 0, "R3", "sclk period errors", bad_period, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule